// File: doc/BRIEF.md
# Livelock Recovery Sequencer

This block sits in a system controller beside a processor that reports trouble on an alert line. When the alert line rises, the sequencer reads the processor's status word. If the status shows a livelock, it runs a fixed series of bit-level writes. The series throttles the main core, quiesces bus traffic, enables a resolution mode, removes the throttle and then resamples the condition. It then reads the status once more. If the livelock has cleared, it undoes the quiesce and pulses a notification for the operating system. If the livelock is still there, it raises a halt output and keeps it raised until reset.

All status traffic goes through a simple request/acknowledge register port. Each write carries a bit mask and the values to place under that mask. A serial link layer outside the block carries these accesses. A second input, driven by an external random-interval source, starts a starvation-relief run of the same recipe with no alert. Accesses are spaced by idle gaps whose lengths come from a free-running LFSR, so that the steps are not evenly timed.

Top module: `livelock_sequencer`

## Requirements
- R1: A rising edge on `alert_in` seen while idle starts a handling run, and its first access is a read of the status word (`reg_we` = 0).
- R2: The status word indicates livelock only when bit 0 and bit 7 are both 1. Otherwise the block makes no write, pulses `other_alert` for one cycle and goes back to idle, where a later request is served normally.
- R3: After a livelock status, exactly four writes follow in this order. The first sets bit 18 (mask 0x40000, data 0x40000). The second sets bits 16, 17 and 19 (mask 0xB0000, data 0xB0000). The third clears bit 18 (mask 0x40000, data 0). The fourth sets bit 4 (mask 0x10, data 0x10). A read of the status word follows them.
- R4: If bit 7 of that second read is 0, the block writes bits 16, 17 and 19 to 0 (mask 0xB0000, data 0) and then pulses `os_notify` for exactly one cycle.
- R5: If bit 7 of that second read is 1, `halt_out` rises and stays at 1 until reset, and no further access is issued.
- R6: A `relax_req` seen while idle runs the four writes of R3, the read, and the clearing write of R4, with no status read first. It gives no `os_notify`, no `other_alert` and no `halt_out`, whatever the read returns.
- R7: Only one access is open at a time. `reg_req`, `reg_we`, `reg_wmask` and `reg_wdata` hold steady until the cycle in which `reg_ack` is sampled high.
- R8: Between two accesses of one run, `reg_req` stays low for at least 1 and at most 2^DELAY_W cycles. The gap length comes from the LFSR and varies from step to step.
- R9: While reset is applied, `reg_req`, `halt_out`, `os_notify` and `other_alert` are all 0.
- R10: When an `alert_in` rising edge and `relax_req` arrive in the same cycle, the alert handling of R1 is the one that runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alert_in | input | 1 | Processor alert line |
| relax_req | input | 1 | Starvation-relief run request |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read of the status word |
| reg_wmask | output | DATA_W | Bits affected by the write |
| reg_wdata | output | DATA_W | Values for the masked bits |
| reg_rdata | input | DATA_W | Status word returned with the acknowledge |
| reg_ack | input | 1 | Access acknowledge, one cycle |
| halt_out | output | 1 | Checkstop request to the processor, sticky |
| os_notify | output | 1 | One-cycle pulse: livelock resolved |
| other_alert | output | 1 | One-cycle pulse: alert was not a livelock |

## Verification
The bench builds the block with its default parameters: a 32-bit status word and a 4-bit gap field, so every gap falls between 1 and 16 cycles. This keeps a complete run under a few hundred cycles. That short run is what makes it possible to sweep every combination of the two decision bits, the resolved and unresolved resample outcomes, and acknowledge latencies from 0 to 3 cycles, for both alert runs and relief runs. The bench also collects the gap lengths seen across the whole sweep, so it can check their bounds and confirm that they vary.

// File: rtl/livelock_sequencer.sv
module livelock_sequencer #(
  parameter int DATA_W = 32,
  parameter int DELAY_W = 4,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alert_in,
  input  logic              relax_req,
  output logic              reg_req,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wmask,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ack,
  output logic              halt_out,
  output logic              os_notify,
  output logic              other_alert
);

  localparam int BIT_FLAG = 0;
  localparam int BIT_LL   = 7;
  localparam int BIT_RSMP = 4;
  localparam int BIT_QDMA = 16;
  localparam int BIT_QCPU = 17;
  localparam int BIT_THR  = 18;
  localparam int BIT_MODE = 19;
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);
  localparam logic [DATA_W-1:0] M_THR  = ONE << BIT_THR;
  localparam logic [DATA_W-1:0] M_QUI  = (ONE << BIT_QDMA) | (ONE << BIT_QCPU) | (ONE << BIT_MODE);
  localparam logic [DATA_W-1:0] M_RSMP = ONE << BIT_RSMP;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_STAT, S_THR_ON, S_QUI_ON, S_THR_OFF,
    S_RESAMP, S_RD_CHK, S_RELEASE, S_GAP, S_HALT
  } st_t;

  st_t st, after_gap;
  logic [DELAY_W-1:0] gap_cnt;
  logic [LFSR_W-1:0]  lfsr;
  logic               alert_q, relax_mode;

  assign reg_req  = st inside {S_RD_STAT, S_THR_ON, S_QUI_ON, S_THR_OFF, S_RESAMP, S_RD_CHK, S_RELEASE};
  assign halt_out = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  always_comb begin
    reg_we    = 1'b1;
    reg_wmask = '0;
    reg_wdata = '0;
    case (st)
      S_THR_ON:  begin reg_wmask = M_THR;  reg_wdata = M_THR;  end
      S_QUI_ON:  begin reg_wmask = M_QUI;  reg_wdata = M_QUI;  end
      S_THR_OFF: begin reg_wmask = M_THR;  reg_wdata = '0;     end
      S_RESAMP:  begin reg_wmask = M_RSMP; reg_wdata = M_RSMP; end
      S_RELEASE: begin reg_wmask = M_QUI;  reg_wdata = '0;     end
      default:   reg_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      after_gap   <= S_IDLE;
      gap_cnt     <= '0;
      relax_mode  <= 1'b0;
      alert_q     <= 1'b0;
      os_notify   <= 1'b0;
      other_alert <= 1'b0;
    end else begin
      alert_q     <= alert_in;
      os_notify   <= 1'b0;
      other_alert <= 1'b0;
      case (st)
        S_IDLE: begin
          if (alert_in && !alert_q) begin
            st <= S_RD_STAT;
            relax_mode <= 1'b0;
          end else if (relax_req) begin
            st <= S_THR_ON;
            relax_mode <= 1'b1;
          end
        end
        S_GAP: begin
          if (gap_cnt == '0) st <= after_gap;
          else               gap_cnt <= gap_cnt - 1'b1;
        end
        S_HALT: ;
        default: begin
          if (reg_ack) begin
            gap_cnt <= lfsr[DELAY_W-1:0];
            st      <= S_GAP;
            case (st)
              S_RD_STAT: begin
                if (reg_rdata[BIT_FLAG] && reg_rdata[BIT_LL]) after_gap <= S_THR_ON;
                else begin
                  st <= S_IDLE;
                  other_alert <= 1'b1;
                end
              end
              S_THR_ON:  after_gap <= S_QUI_ON;
              S_QUI_ON:  after_gap <= S_THR_OFF;
              S_THR_OFF: after_gap <= S_RESAMP;
              S_RESAMP:  after_gap <= S_RD_CHK;
              S_RD_CHK: begin
                if (reg_rdata[BIT_LL] && !relax_mode) st <= S_HALT;
                else after_gap <= S_RELEASE;
              end
              S_RELEASE: begin
                st <= S_IDLE;
                os_notify <= !relax_mode;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_we) && $stable(reg_wmask) && $stable(reg_wdata)); // R7
  AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_ack |=> !reg_req); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_out |=> halt_out); // R5
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt_out |-> !reg_req); // R5
  AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    os_notify |=> !os_notify); // R4
  AST_NOTIFY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(os_notify) |-> $past(reg_ack) && $past(reg_we)); // R4
  AST_OTHER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    other_alert |=> !other_alert); // R2

endmodule

// File: tb/livelock_sequencer_tb.sv
`timescale 1ns/1ps
module livelock_sequencer_tb;
  localparam int DW = 32;
  localparam int DLY = 4;
  localparam logic [DW-1:0] M_THR = 32'h0004_0000;
  localparam logic [DW-1:0] M_QUI = 32'h000B_0000;
  localparam logic [DW-1:0] M_RS  = 32'h0000_0010;

  logic clk = 0, rst_n = 0, alert_in = 0, relax_req = 0;
  logic reg_req, reg_we, reg_ack = 0, halt_out, os_notify, other_alert;
  logic [DW-1:0] reg_wmask, reg_wdata, reg_rdata = '0;

  always #2 clk = ~clk;

  livelock_sequencer #(.DATA_W(DW), .DELAY_W(DLY)) u_dut (
    .clk, .rst_n, .alert_in, .relax_req, .reg_req, .reg_we, .reg_wmask, .reg_wdata,
    .reg_rdata, .reg_ack, .halt_out, .os_notify, .other_alert);

  int checks = 0, errors = 0;
  bit finished = 0;
  int lat = 0;
  logic [DW-1:0] st1, st2;
  int rd_idx, log_n, idle_run, lat_cnt, n_notify, n_other, gmin = 999, gmax = -1;
  bit have_prev, in_acc;
  logic [DW-1:0] log_mask [16], log_data [16], hold_mask, hold_data;
  logic log_we [16], hold_we;
  bit gap_seen [64];
  logic [DW-1:0] e_mask [16], e_data [16];
  logic e_we [16];
  int e_n;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0; rd_idx = 0; have_prev = 0; in_acc = 0; idle_run = 0; lat_cnt = 0;
    n_notify = 0; n_other = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      reg_ack = 0;
    end else begin
      if (os_notify) n_notify++;
      if (other_alert) n_other++;
      if (reg_ack) begin
        reg_ack = 0;
        if (!reg_req) idle_run++;
      end else if (reg_req) begin
        if (!in_acc) begin
          in_acc = 1;
          hold_we = reg_we; hold_mask = reg_wmask; hold_data = reg_wdata;
          if (have_prev) begin
            if (idle_run < gmin) gmin = idle_run;
            if (idle_run > gmax) gmax = idle_run;
            if (idle_run >= 0 && idle_run < 64) gap_seen[idle_run] = 1;
          end
        end else if (reg_we !== hold_we || reg_wmask !== hold_wmask_f() || reg_wdata !== hold_data) begin
          chk(0, "R7 fields changed before ack", {reg_wmask}, {hold_mask});
        end
        if (lat_cnt == lat) begin
          reg_ack = 1;
          reg_rdata = reg_we ? '0 : (rd_idx == 0 ? st1 : st2);
          if (!reg_we) rd_idx++;
          if (log_n < 16) begin
            log_we[log_n] = reg_we; log_mask[log_n] = reg_wmask; log_data[log_n] = reg_wdata;
          end
          log_n++;
          lat_cnt = 0; in_acc = 0; have_prev = 1; idle_run = 0;
        end else lat_cnt++;
      end else idle_run++;
    end
  end

  function automatic logic [DW-1:0] hold_wmask_f();
    return hold_mask;
  endfunction

  task automatic push(input logic we, input logic [DW-1:0] m, input logic [DW-1:0] d);
    e_we[e_n] = we; e_mask[e_n] = m; e_data[e_n] = d; e_n++;
  endtask

  task automatic do_reset();
    rst_n = 0; alert_in = 0; relax_req = 0;
    repeat (3) @(negedge clk);
    chk(reg_req === 0 && halt_out === 0 && os_notify === 0 && other_alert === 0,
        "R9 outputs in reset", {reg_req, halt_out, os_notify, other_alert}, 0);
    clear_log();
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic compare(input string tag, input int exp_notify, input int exp_other, input logic exp_halt);
    chk(log_n == e_n, {tag, " access count"}, log_n, e_n);
    for (int i = 0; i < e_n && i < log_n; i++) begin
      chk(log_we[i] === e_we[i] && log_mask[i] === e_mask[i] && log_data[i] === e_data[i],
          $sformatf("%s access %0d", tag, i), {log_we[i], log_mask[i]}, {e_we[i], e_mask[i]});
    end
    chk(n_notify == exp_notify, "R4 os_notify pulses", n_notify, exp_notify);
    chk(n_other == exp_other, "R2 other_alert pulses", n_other, exp_other);
    chk(halt_out === exp_halt, "R5 halt_out level", halt_out, exp_halt);
  endtask

  task automatic expect_recipe(input bit relax, input bit resolved);
    push(1, M_THR, M_THR);
    push(1, M_QUI, M_QUI);
    push(1, M_THR, '0);
    push(1, M_RS, M_RS);
    push(0, '0, '0);
    if (relax || resolved) push(1, M_QUI, '0);
  endtask

  task automatic run_alert(input logic [DW-1:0] s1, input logic [DW-1:0] s2, input bit both);
    bit ll, res;
    st1 = s1; st2 = s2;
    do_reset();
    alert_in = 1; relax_req = both;
    @(negedge clk);
    relax_req = 0;
    repeat (400) @(negedge clk);
    ll = s1[0] & s1[7];
    res = !s2[7];
    e_n = 0;
    push(0, '0, '0);
    if (ll) expect_recipe(0, res);
    compare(both ? "R10 simultaneous" : (ll ? "R3 recipe" : "R2 no writes"),
            (ll && res) ? 1 : 0, ll ? 0 : 1, ll && !res);
    chk(log_n > 0 && log_we[0] === 0, "R1 first access is read", log_we[0], 0);
  endtask

  task automatic run_relax(input logic [DW-1:0] s2, input bit fresh);
    st1 = s2; st2 = s2;
    if (fresh) do_reset();
    else clear_log();
    relax_req = 1;
    @(negedge clk);
    relax_req = 0;
    repeat (400) @(negedge clk);
    e_n = 0;
    expect_recipe(1, 1);
    compare("R6 relief run", 0, 0, 0);
  endtask

  initial begin
    logic [DW-1:0] s1v [6];
    logic [DW-1:0] s2v [2];
    int distinct;
    s1v = '{32'h0, 32'h1, 32'h80, 32'h81, 32'hFFFF_FF7F, 32'hFFFF_FFFF};
    s2v = '{32'hFFFF_FF7F, 32'h0000_0080};
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 2; b++) run_alert(s1v[a], s2v[b], 0);
      for (int b = 0; b < 2; b++) run_relax(s2v[b], 1);
      run_alert(32'h1, 32'h0, 0);
      alert_in = 0;
      run_relax(32'h80, 0);
    end
    lat = 1;
    run_alert(32'h81, 32'h0, 1);
    chk(gmin >= 1, "R8 minimum gap", gmin, 1);
    chk(gmax <= (1 << DLY) && gmax >= 1, "R8 maximum gap", gmax, 1 << DLY);
    distinct = 0;
    for (int i = 0; i < 64; i++) if (gap_seen[i]) distinct++;
    chk(distinct >= 2, "R8 gap lengths vary", distinct, 2);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule